// File: doc/BRIEF.md
# Timed Device Reset Sequencer with Retry

This block brings an external device out of reset through a fixed, timed procedure and then judges whether the device came up healthy. After a start request, it pulls an active-low reset line down and holds it for a number of millisecond ticks. It then waits until the board reports that its clocks are stable, and holds the line for a further stretch before letting go. After release it allows time for the device's internal timers to run out and for its serial link to settle. Only then does it look at the device's status inputs.

The status check passes only when all three of these hold: the parallel-side timer reports expiry, none of the out-of-lock flags is raised, and the serial-side timer reports expiry. A failed check starts the whole procedure over, with the reset line pulled low again. This repeats up to a fixed number of attempts and stops at the first pass. When the procedure ends, a single-cycle completion pulse is raised. A pass/fail flag goes with it and keeps its value until the next start is accepted.

All waits are counted in ticks of an externally supplied 1 ms strobe. A sub-millisecond settle time is rounded up to one whole tick.

Top module: `dev_reset_sequencer`

## Requirements
- R1: After reset the block is idle: `dev_rst_n` is 1, and `busy`, `done` and `success` are 0.
- R2: A `start_req` sampled while idle is accepted. One cycle later `dev_rst_n` is 0, `busy` is 1 and `success` is 0.
- R3: In each attempt, `dev_rst_n` stays low for PRE_TICKS ticks. It then waits for `clks_stable`, and then stays low for POST_TICKS further ticks with `clks_stable` high. With `clks_stable` already high and the defaults, each attempt spends exactly 4 ticks low.
- R4: `dev_rst_n` is never released while `clks_stable` is low. After `clks_stable` rises, the line stays low for exactly POST_TICKS more ticks.
- R5: After release, the block lets SETTLE_TICKS + LINK_TICKS ticks pass (15 + 1 by default) with `dev_rst_n` high and `busy` high before it evaluates the status.
- R6: The status check passes only when `pl4_timer_done` is 1, every bit of `lock_lost` is 0, and `xaui_timer_done` is 1. Any one of them failing fails the check.
- R7: A failed check that is not the last attempt starts a new attempt, with `dev_rst_n` pulled low again. There are at most MAX_TRIES attempts (3 by default), and the block stops at the first pass.
- R8: When the check fails on the last allowed attempt, the block finishes with `success` = 0.
- R9: `done` is a single-cycle pulse. It is raised exactly once per accepted start, and `busy` is 0 in that cycle.
- R10: `success` holds its final value while the block is idle, until the next accepted start clears it.
- R11: A `start_req` that arrives while `busy` is 1 has no effect: the attempt count, the phase lengths and the single `done` pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to run the reset procedure (used only while idle) |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| clks_stable | input | 1 | High when the device's reference clocks are stable |
| pl4_timer_done | input | 1 | Parallel-side internal timer has expired |
| lock_lost | input | LOCK_W | Out-of-lock flags; any bit set fails the check |
| xaui_timer_done | input | 1 | Serial-side internal timer has expired |
| dev_rst_n | output | 1 | Active-low reset to the device |
| busy | output | 1 | Procedure in progress |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Result of the last completed procedure |

## Verification
The bench builds the block with its default phase lengths (2 + 2 ticks low, 15 + 1 ticks high), three attempts and a four-bit lock vector. It strobes `ms_tick` every 8 clocks, so even a run that fails all three attempts finishes within a few hundred cycles. These short phases let the bench count every tick of every phase exactly. They also make it practical to test each lock bit on its own and to check that a status fixed during a run is picked up on the second attempt. Holding `clks_stable` low for several ticks shows that the wait for stable clocks can stretch for as long as needed.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Sequencer phases.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HOLD_A,
        SQ_WAIT_CLK,
        SQ_HOLD_B,
        SQ_SETTLE,
        SQ_LINK,
        SQ_CHECK
    } seq_state_e;

    // Outcome of the status evaluation.
    typedef enum logic [1:0] {
        VERDICT_NONE,
        VERDICT_PASS,
        VERDICT_RETRY,
        VERDICT_FAIL
    } verdict_e;

    // Status seen at the end of an attempt.
    typedef struct packed {
        logic pl4_expired;
        logic any_lock_lost;
        logic xaui_expired;
    } dev_status_t;

    // Phases during which the device reset line is held low.
    function automatic logic holds_reset(seq_state_e s);
        return (s == SQ_HOLD_A) || (s == SQ_WAIT_CLK) || (s == SQ_HOLD_B);
    endfunction

    // Phases whose length is counted in millisecond ticks.
    function automatic logic timed_phase(seq_state_e s);
        return (s == SQ_HOLD_A) || (s == SQ_HOLD_B) ||
               (s == SQ_SETTLE) || (s == SQ_LINK);
    endfunction

    // Healthy when both timers expired and no lock has been lost.
    function automatic logic status_ok(dev_status_t st);
        return st.pl4_expired && !st.any_lock_lost && st.xaui_expired;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rstseq_tick_timer.sv
module rstseq_tick_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic             ms_tick,
    input  logic [CNT_W-1:0] target,
    output logic             expired
);
    logic [CNT_W-1:0] count_q;

    // Count ticks within the current phase; a phase change restarts it.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count_q <= '0;
        end else if (run && ms_tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    // The target-th tick of the phase ends it.
    assign expired = run && ms_tick && (count_q == target - 1'b1);

endmodule

// File: rtl/rstseq_health.sv
module rstseq_health
    import rstseq_pkg::*;
#(
    parameter int LOCK_W = 4
) (
    input  logic              pl4_timer_done,
    input  logic [LOCK_W-1:0] lock_lost,
    input  logic              xaui_timer_done,
    output logic              healthy
);
    dev_status_t st;

    always_comb begin
        st.pl4_expired   = pl4_timer_done;
        st.any_lock_lost = |lock_lost;
        st.xaui_expired  = xaui_timer_done;
        healthy          = status_ok(st);
    end

endmodule

// File: rtl/rstseq_attempts.sv
module rstseq_attempts #(
    parameter int MAX_TRIES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic first,
    input  logic bump,
    output logic last
);
    localparam int AW = $clog2(MAX_TRIES + 1);

    logic [AW-1:0] tries_q;

    // Number of the attempt in progress, starting at one.
    always_ff @(posedge clk) begin
        if (rst) begin
            tries_q <= '0;
        end else if (first) begin
            tries_q <= AW'(1);
        end else if (bump) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign last = (tries_q >= AW'(MAX_TRIES));

endmodule

// File: rtl/dev_reset_sequencer.sv
module dev_reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int PRE_TICKS    = 2,
    parameter int POST_TICKS   = 2,
    parameter int SETTLE_TICKS = 15,
    parameter int LINK_TICKS   = 1,
    parameter int MAX_TRIES    = 3,
    parameter int LOCK_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              ms_tick,
    input  logic              clks_stable,
    input  logic              pl4_timer_done,
    input  logic [LOCK_W-1:0] lock_lost,
    input  logic              xaui_timer_done,
    output logic              dev_rst_n,
    output logic              busy,
    output logic              done,
    output logic              success
);
    localparam int MAX_PHASE = max2(max2(PRE_TICKS, POST_TICKS),
                                    max2(SETTLE_TICKS, LINK_TICKS));
    localparam int CNT_W     = $clog2(MAX_PHASE + 1);

    seq_state_e       state_q, state_d;
    verdict_e         verdict;
    logic             phase_end;
    logic             phase_restart;
    logic [CNT_W-1:0] phase_len;
    logic             healthy;
    logic             last_try;
    logic             accept;
    logic             retry;
    logic             done_q, success_q;

    // Length of the phase in progress.
    always_comb begin
        unique case (state_q)
            SQ_HOLD_A: phase_len = CNT_W'(PRE_TICKS);
            SQ_HOLD_B: phase_len = CNT_W'(POST_TICKS);
            SQ_SETTLE: phase_len = CNT_W'(SETTLE_TICKS);
            SQ_LINK:   phase_len = CNT_W'(LINK_TICKS);
            default:   phase_len = CNT_W'(1);
        endcase
    end

    rstseq_tick_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(phase_restart),
        .run    (timed_phase(state_q)),
        .ms_tick(ms_tick),
        .target (phase_len),
        .expired(phase_end)
    );

    rstseq_health #(
        .LOCK_W(LOCK_W)
    ) u_health (
        .pl4_timer_done (pl4_timer_done),
        .lock_lost      (lock_lost),
        .xaui_timer_done(xaui_timer_done),
        .healthy        (healthy)
    );

    rstseq_attempts #(
        .MAX_TRIES(MAX_TRIES)
    ) u_tries (
        .clk  (clk),
        .rst  (rst),
        .first(accept),
        .bump (retry),
        .last (last_try)
    );

    // Verdict is only meaningful in the check phase.
    always_comb begin
        verdict = VERDICT_NONE;
        if (state_q == SQ_CHECK) begin
            if (healthy) begin
                verdict = VERDICT_PASS;
            end else if (last_try) begin
                verdict = VERDICT_FAIL;
            end else begin
                verdict = VERDICT_RETRY;
            end
        end
    end

    assign accept = (state_q == SQ_IDLE) && start_req;
    assign retry  = (verdict == VERDICT_RETRY);

    // Phase sequencing.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start_req) state_d = SQ_HOLD_A;
            end
            SQ_HOLD_A: begin
                if (phase_end) state_d = clks_stable ? SQ_HOLD_B : SQ_WAIT_CLK;
            end
            SQ_WAIT_CLK: begin
                if (clks_stable) state_d = SQ_HOLD_B;
            end
            SQ_HOLD_B: begin
                if (!clks_stable)   state_d = SQ_WAIT_CLK;
                else if (phase_end) state_d = SQ_SETTLE;
            end
            SQ_SETTLE: begin
                if (phase_end) state_d = SQ_LINK;
            end
            SQ_LINK: begin
                if (phase_end) state_d = SQ_CHECK;
            end
            SQ_CHECK: begin
                state_d = retry ? SQ_HOLD_A : SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    assign phase_restart = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Completion pulse and held result.
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            success_q <= 1'b0;
        end else begin
            done_q <= (verdict == VERDICT_PASS) || (verdict == VERDICT_FAIL);
            if (accept) begin
                success_q <= 1'b0;
            end else if (verdict == VERDICT_PASS) begin
                success_q <= 1'b1;
            end
        end
    end

    assign dev_rst_n = !holds_reset(state_q);
    assign busy      = (state_q != SQ_IDLE);
    assign done      = done_q;
    assign success   = success_q;

endmodule

// File: rtl/dev_reset_sequencer_chk.sv
module dev_reset_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic start_req,
    input logic clks_stable,
    input logic dev_rst_n,
    input logic busy,
    input logic done,
    input logic success
);
    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the pulse comes with the block idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: leaving the busy state always signals completion
    p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R4: no release while clocks are unstable
    p_hold_clk_r4: assert property (@(posedge clk) disable iff (rst)
        (!dev_rst_n && !clks_stable) |=> !dev_rst_n);

    // R10: result holds while idle and no start arrives
    p_success_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_req) |=> $stable(success));

    // R2: an accepted start pulls reset low and clears the result
    p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_req) |=> (busy && !dev_rst_n && !success));

endmodule

bind dev_reset_sequencer dev_reset_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .clks_stable(clks_stable),
    .dev_rst_n  (dev_rst_n),
    .busy       (busy),
    .done       (done),
    .success    (success)
);

// File: tb/test_dev_reset_sequencer.sv
module test_dev_reset_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 8;
    localparam int LOCK_W     = 4;
    localparam int LOW_EXP    = 4;
    localparam int HIGH_EXP   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_req = 1'b0;
    logic              ms_tick = 1'b0;
    logic              clks_stable = 1'b1;
    logic              pl4_timer_done = 1'b1;
    logic [LOCK_W-1:0] lock_lost = '0;
    logic              xaui_timer_done = 1'b1;
    logic              dev_rst_n, busy, done, success;

    int n_checks = 0;
    int n_fails  = 0;

    dev_reset_sequencer i_dev_reset_sequencer (
        .clk            (clk),
        .rst            (rst),
        .start_req      (start_req),
        .ms_tick        (ms_tick),
        .clks_stable    (clks_stable),
        .pl4_timer_done (pl4_timer_done),
        .lock_lost      (lock_lost),
        .xaui_timer_done(xaui_timer_done),
        .dev_rst_n      (dev_rst_n),
        .busy           (busy),
        .done           (done),
        .success        (success)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Millisecond strobe, updated just after each rising edge.
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
            ms_tick = (cnt == TICK_DIV - 1);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_status(input logic pl4, input logic [LOCK_W-1:0] lk, input logic xaui);
        pl4_timer_done  = pl4;
        lock_lost       = lk;
        xaui_timer_done = xaui;
    endtask

    // Start one run and watch it to completion.
    task automatic drive_run(input int heal_fall, input int poke_cyc,
                             output int falls, output int low1, output int high1,
                             output int dones, output logic succ);
        bit seen_done = 0;
        int post = 0;
        logic prev_rst;
        falls = 0; low1 = 0; high1 = 0; dones = 0; succ = 1'bx;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check(dev_rst_n == 1'b0, "R2 reset low after start", int'(dev_rst_n), 0);
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        check(success == 1'b0, "R10 result cleared by start", int'(success), 0);
        prev_rst = 1'b1;
        for (int c = 0; c < 4000; c++) begin
            if (prev_rst && !dev_rst_n) falls++;
            if (ms_tick && falls == 1) begin
                if (!dev_rst_n) low1++;
                else if (busy) high1++;
            end
            if (done) begin
                dones++;
                succ = success;
                seen_done = 1;
                check(busy == 1'b0, "R9 idle during done", int'(busy), 0);
            end
            prev_rst = dev_rst_n;
            if (heal_fall > 0 && falls >= heal_fall) set_status(1'b1, '0, 1'b1);
            start_req = (c == poke_cyc);
            if (seen_done) begin
                post++;
                if (post > 6) break;
            end
            @(negedge clk);
        end
        start_req = 1'b0;
        if (!seen_done) check(1'b0, "watchdog run finished", 0, 1);
    endtask

    task automatic t_reset_state;
        check(dev_rst_n == 1'b1, "R1 reset line idle high", int'(dev_rst_n), 1);
        check(busy == 1'b0, "R1 busy low", int'(busy), 0);
        check(done == 1'b0, "R1 done low", int'(done), 0);
        check(success == 1'b0, "R1 success low", int'(success), 0);
    endtask

    task automatic t_clean_pass;
        int f, lo, hi, d; logic s;
        set_status(1'b1, '0, 1'b1);
        drive_run(0, -1, f, lo, hi, d, s);
        check(lo == LOW_EXP, "R3 ticks held low", lo, LOW_EXP);
        check(hi == HIGH_EXP, "R5 ticks after release", hi, HIGH_EXP);
        check(f == 1, "R7 single attempt on pass", f, 1);
        check(d == 1, "R9 one done pulse", d, 1);
        check(s == 1'b1, "R6 pass with good status", int'(s), 1);
    endtask

    task automatic t_hold_result;
        repeat (30) @(negedge clk);
        check(success == 1'b1, "R10 result held while idle", int'(success), 1);
        check(done == 1'b0, "R9 no extra done", int'(done), 0);
    endtask

    task automatic t_all_fail(input logic pl4, input logic [LOCK_W-1:0] lk,
                              input logic xaui, input string tag);
        int f, lo, hi, d; logic s;
        set_status(pl4, lk, xaui);
        drive_run(0, -1, f, lo, hi, d, s);
        check(f == 3, {"R7 three attempts ", tag}, f, 3);
        check(d == 1, {"R9 one done ", tag}, d, 1);
        check(s == 1'b0, {"R8 failure reported ", tag}, int'(s), 0);
        check(lo == LOW_EXP, {"R3 low ticks ", tag}, lo, LOW_EXP);
        set_status(1'b1, '0, 1'b1);
    endtask

    task automatic t_lock_bits;
        for (int b = 0; b < LOCK_W; b++) begin
            logic [LOCK_W-1:0] m = '0;
            m[b] = 1'b1;
            t_all_fail(1'b1, m, 1'b1, $sformatf("R6 lock bit %0d", b));
        end
    endtask

    task automatic t_heal_second;
        int f, lo, hi, d; logic s;
        set_status(1'b1, 4'b0100, 1'b1);
        drive_run(2, -1, f, lo, hi, d, s);
        check(f == 2, "R7 stop at first pass", f, 2);
        check(s == 1'b1, "R7 pass on second attempt", int'(s), 1);
        check(d == 1, "R9 one done on retry pass", d, 1);
    endtask

    task automatic t_busy_start;
        int f, lo, hi, d; logic s;
        set_status(1'b1, '0, 1'b1);
        drive_run(0, 40, f, lo, hi, d, s);
        check(f == 1, "R11 start while busy ignored", f, 1);
        check(lo + hi == LOW_EXP + HIGH_EXP, "R11 phase ticks unchanged", lo + hi, LOW_EXP + HIGH_EXP);
        check(d == 1, "R11 single done", d, 1);
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R11 no second run", int'(busy), 0);
    endtask

    task automatic t_clock_wait;
        int lo = 0, after = 0;
        set_status(1'b1, '0, 1'b1);
        clks_stable = 1'b0;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int c = 0; c < 2000 && lo < 6; c++) begin
            if (ms_tick && !dev_rst_n) lo++;
            if (lo < 6) @(negedge clk);
        end
        check(dev_rst_n == 1'b0, "R4 held while clocks unstable", int'(dev_rst_n), 0);
        clks_stable = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 2000 && !dev_rst_n; c++) begin
            if (ms_tick) after++;
            @(negedge clk);
        end
        check(after == 2, "R4 ticks after clocks stable", after, 2);
        for (int c = 0; c < 2000 && !done; c++) @(negedge clk);
        check(success == 1'b1, "R4 pass after clock wait", int'(success), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_clean_pass();
        t_hold_result();
        t_all_fail(1'b0, '0, 1'b1, "pl4 timer");
        t_all_fail(1'b1, '0, 1'b0, "xaui timer");
        t_lock_bits();
        t_heal_second();
        t_busy_start();
        t_clock_wait();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule